// File: doc/BRIEF.md
# D-PHY Timing Parameter Generator

This block turns a per-lane link data rate, given in Mbps, into the set of D-PHY timing counts a serial display transmitter needs. Every count is expressed in byte-clock cycles. A single start pulse launches one computation. The block first derives two base periods from the rate: the unit interval and the byte cycle time. It then evaluates a fixed offset formula for each high-speed and turnaround interval, rounding up where the formula calls for it. All of these quotients come from one shared sequential integer divider.

When the computation ends, the block packs the fields into four 32-bit words and pulses `done_o`. The words hold their values until the next computation completes. A board may replace any field before packing by asserting that field's bit in an override mask. Each computed field saturates at its byte limit, and a saturation raises a sticky overflow flag. A zero rate is refused at once with an error flag.

Top module: `dphy_tim_gen`

## Requirements
- R1: The unit interval is floor(1000/rate)+1 and the byte cycle time is floor(8000/rate)+1. Every other field is derived from these two periods.
- R2: Data-lane fields, where ceil(x) means x divided by the cycle time and rounded up: lpx = ceil(60), hs_prepare = ceil(50+5·UI), hs_zero = ceil(110+6·UI), hs_trail = ceil(77+4·UI).
- R3: Turnaround and exit fields come from the computed lpx: ta_go = 4·lpx, ta_sure = floor(3·lpx/2), ta_get = 5·lpx, data hs_exit = 2·lpx, clock hs_exit = 2·lpx.
- R4: Clock-lane fields: hs_sync = 1, clk_zero = ceil(336), clk_trail = ceil(100)+10, clk_prepare = ceil(64), clk_post = ceil(80+52·UI).
- R5: Word packing:
  - word0 = {hs_trail, hs_zero, hs_prepare, lpx}
  - word1 = {hs_exit, ta_get, ta_sure, ta_go}
  - word2 = {clk_trail, clk_zero, hs_sync, 8'h00}
  - word3 = {8'h00, clk_exit, clk_post, clk_prepare}

  Each word is listed from bits [31:24] down to [7:0].
- R6: A computed field above 255 is packed as 255, and `ovf_o` then rises. Once set, `ovf_o` stays set until reset.
- R7: Field index order for overrides is lpx=0, hs_prepare=1, hs_zero=2, hs_trail=3, ta_go=4, ta_sure=5, ta_get=6, hs_exit=7, hs_sync=8, clk_zero=9, clk_trail=10, clk_prepare=11, clk_post=12, clk_exit=13. If bit i of `ovr_mask_i` is set when the start is accepted, field i is packed as `ovr_data_i[8i+7:8i]`. An overridden field never counts as saturated, and derived fields still use the computed lpx.
- R8: A start with rate 0 gives `done_o` and `err_o` in the next cycle and leaves the words unchanged. A successful completion clears `err_o`.
- R9: An accepted nonzero start raises `busy_o` on the next cycle. `done_o` pulses for one cycle exactly 10·(DIV_W+2)+1 cycles after the start edge, which is 341 with the defaults. `busy_o` falls on that same edge.
- R10: A start while `busy_o` is high is ignored and does not change the result.
- R11: The output words change only on the edge that raises `done_o`, and stay stable otherwise.
- R12: After reset, all words are zero and `busy_o`, `done_o`, `err_o` and `ovf_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse |
| rate_i | input | RATE_W | Per-lane data rate in Mbps |
| ovr_mask_i | input | 14 | Per-field override enable |
| ovr_data_i | input | 112 | Override values, 8 bits per field |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle completion strobe |
| err_o | output | 1 | Last request had zero rate |
| ovf_o | output | 1 | Sticky field saturation flag |
| word0_o | output | 32 | Data-lane HS word |
| word1_o | output | 32 | Turnaround/exit word |
| word2_o | output | 32 | Clock zero/trail word |
| word3_o | output | 32 | Clock prepare/post/exit word |

## Verification
The bench covers several distinct situations:
- Low rates, where the rounding behaviour of the divisions shows in the results; an off-by-one in the period or ceiling arithmetic would shift a field by one.
- Very high rates, where ta_get and clk_zero exceed a byte. A design that wraps instead of clamping would pack small values and leave the overflow flag low.
- The same high rate with those two fields overridden. Here the overflow flag must stay low, and a design that checks saturation before the override would raise it.
- A zero rate, which must return at once with no division.
- A start while busy, which must not change the result.
- A start in the very cycle of completion, which must be accepted.

A latency that is off by one cycle shows up in the per-clock comparison of `done_o` and `busy_o`.

// File: rtl/dphy_tim_pkg.sv
package dphy_tim_pkg;

   localparam int NUM_FIELDS = 14;
   localparam int FIELD_W    = 8;
   localparam int NUM_QUOT   = 8;
   localparam int NUM_STEPS  = NUM_QUOT + 2;
   localparam int NUM_SLOTS  = 16;

   typedef enum logic [1:0] {
      S_IDLE  = 2'd0,
      S_ISSUE = 2'd1,
      S_WAIT  = 2'd2,
      S_PACK  = 2'd3
   } seq_state_t;

   // constant term of each rounded-up quotient
   function automatic int quot_base(input int idx);
      case (idx)
         0:       return 60;
         1:       return 50;
         2:       return 110;
         3:       return 77;
         4:       return 336;
         5:       return 100;
         6:       return 64;
         default: return 80;
      endcase
   endfunction

   // multiplier of the unit interval in each quotient numerator
   function automatic int quot_coef(input int idx);
      case (idx)
         1:       return 5;
         2:       return 6;
         3:       return 4;
         7:       return 52;
         default: return 0;
      endcase
   endfunction

   // byte slot (word*4 + byte) to field index, -1 for a zero byte
   function automatic int slot_field(input int slot);
      case (slot)
         8:       return -1;
         9:       return 8;
         10:      return 9;
         11:      return 10;
         12:      return 11;
         13:      return 12;
         14:      return 13;
         15:      return -1;
         default: return slot;
      endcase
   endfunction

endpackage

// File: rtl/dphy_tim_div.sv
module dphy_tim_div #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic [W-1:0] num,
   input  logic [W-1:0] den,
   output logic         done,
   output logic [W-1:0] quo
);
   localparam int CNT_W = $clog2(W + 1);

   logic [W:0]       rem_r;
   logic [W-1:0]     qr_r;
   logic [W-1:0]     den_h;
   logic [W-1:0]     num_h;
   logic [CNT_W-1:0] cnt_r;
   logic             run_r;
   logic             done_r;
   logic [W:0]       shifted;
   logic             fits;

   assign shifted = {rem_r[W-1:0], qr_r[W-1]};
   assign fits    = shifted >= {1'b0, den_h};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_r  <= '0;
         qr_r   <= '0;
         den_h  <= '0;
         num_h  <= '0;
         cnt_r  <= '0;
         run_r  <= 1'b0;
         done_r <= 1'b0;
      end else begin
         done_r <= 1'b0;
         if (go) begin
            rem_r <= '0;
            qr_r  <= num;
            den_h <= den;
            num_h <= num;
            cnt_r <= CNT_W'(W);
            run_r <= 1'b1;
         end else if (run_r) begin
            rem_r <= fits ? (shifted - {1'b0, den_h}) : shifted;
            qr_r  <= {qr_r[W-2:0], fits};
            cnt_r <= cnt_r - CNT_W'(1);
            if (cnt_r == CNT_W'(1)) begin
               run_r  <= 1'b0;
               done_r <= 1'b1;
            end
         end
      end
   end

   assign done = done_r;
   assign quo  = qr_r;

   // R1
   div_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_r |-> (({{W{1'b0}}, qr_r} * {{W{1'b0}}, den_h}) + {{W{1'b0}}, rem_r[W-1:0]}
                  == {{W{1'b0}}, num_h}) && (rem_r[W-1:0] < den_h));

endmodule

// File: rtl/dphy_tim_seq.sv
module dphy_tim_seq
   import dphy_tim_pkg::*;
#(
   parameter int W      = 32,
   parameter int RATE_W = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   input  logic [RATE_W-1:0]          rate,
   output logic                       busy,
   output logic                       fin,
   output logic [NUM_QUOT-1:0][W-1:0] quots
);
   localparam int STEP_W = $clog2(NUM_STEPS);
   localparam int QI_W   = $clog2(NUM_QUOT);

   seq_state_t                 st_r;
   logic [STEP_W-1:0]          step_r;
   logic [RATE_W-1:0]          rate_r;
   logic [W-1:0]               ui_r;
   logic [W-1:0]               cy_r;
   logic [NUM_QUOT-1:0][W-1:0] q_r;
   logic [W-1:0]               num;
   logic [W-1:0]               den;
   logic [QI_W-1:0]            qidx;
   logic                       div_done;
   logic [W-1:0]               div_q;

   assign qidx = QI_W'(step_r - STEP_W'(2));

   always_comb begin
      if (step_r == STEP_W'(0)) begin
         num = W'(1000);
         den = W'(rate_r);
      end else if (step_r == STEP_W'(1)) begin
         num = W'(8000);
         den = W'(rate_r);
      end else begin
         num = W'(quot_base(int'(qidx))) + W'(quot_coef(int'(qidx))) * ui_r
               + cy_r - W'(1);
         den = cy_r;
      end
   end

   dphy_tim_div #(.W(W)) div_i (
      .clk  (clk),
      .rst_n(rst_n),
      .go   (st_r == S_ISSUE),
      .num  (num),
      .den  (den),
      .done (div_done),
      .quo  (div_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_r   <= S_IDLE;
         step_r <= '0;
         rate_r <= '0;
         ui_r   <= '0;
         cy_r   <= '0;
         q_r    <= '0;
      end else begin
         case (st_r)
            S_IDLE: begin
               if (start && (rate != '0)) begin
                  rate_r <= rate;
                  step_r <= '0;
                  st_r   <= S_ISSUE;
               end
            end
            S_ISSUE: st_r <= S_WAIT;
            S_WAIT: begin
               if (div_done) begin
                  if (step_r == STEP_W'(0))      ui_r <= div_q + W'(1);
                  else if (step_r == STEP_W'(1)) cy_r <= div_q + W'(1);
                  else                           q_r[qidx] <= div_q;
                  if (step_r == STEP_W'(NUM_STEPS - 1)) begin
                     st_r <= S_PACK;
                  end else begin
                     step_r <= step_r + STEP_W'(1);
                     st_r   <= S_ISSUE;
                  end
               end
            end
            default: st_r <= S_IDLE;
         endcase
      end
   end

   assign busy  = (st_r != S_IDLE);
   assign fin   = (st_r == S_PACK);
   assign quots = q_r;

   // R10
   start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && busy) |=> $stable(rate_r));

   // R1
   period_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_r == S_ISSUE && step_r > STEP_W'(1)) |-> (cy_r != '0));

endmodule

// File: rtl/dphy_tim_pack.sv
module dphy_tim_pack
   import dphy_tim_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [NUM_QUOT-1:0][W-1:0]     quots,
   input  logic [NUM_FIELDS-1:0]          ovr_mask,
   input  logic [NUM_FIELDS*FIELD_W-1:0]  ovr_data,
   output logic [3:0][4*FIELD_W-1:0]      words,
   output logic                           sat_any
);
   localparam logic [W-1:0] FMAX = W'((1 << FIELD_W) - 1);

   logic [NUM_FIELDS-1:0][W-1:0]       raw;
   logic [NUM_FIELDS-1:0][FIELD_W-1:0] fld;
   logic [NUM_FIELDS-1:0]              sat;
   logic [W-1:0]                       lpx;

   assign lpx = quots[0];

   always_comb begin
      raw[0]  = lpx;
      raw[1]  = quots[1];
      raw[2]  = quots[2];
      raw[3]  = quots[3];
      raw[4]  = lpx << 2;
      raw[5]  = (lpx + (lpx << 1)) >> 1;
      raw[6]  = lpx + (lpx << 2);
      raw[7]  = lpx << 1;
      raw[8]  = W'(1);
      raw[9]  = quots[4];
      raw[10] = quots[5] + W'(10);
      raw[11] = quots[6];
      raw[12] = quots[7];
      raw[13] = lpx << 1;
   end

   for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
      assign sat[f] = !ovr_mask[f] && (raw[f] > FMAX);
      assign fld[f] = ovr_mask[f] ? ovr_data[f*FIELD_W +: FIELD_W]
                    : (sat[f] ? FMAX[FIELD_W-1:0] : raw[f][FIELD_W-1:0]);
   end

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      localparam int FI = slot_field(s);
      if (FI < 0) begin : g_zero
         assign words[s/4][(s%4)*FIELD_W +: FIELD_W] = '0;
      end else begin : g_map
         assign words[s/4][(s%4)*FIELD_W +: FIELD_W] = fld[FI];
      end
   end

   assign sat_any = |sat;

endmodule

// File: rtl/dphy_tim_gen.sv
module dphy_tim_gen
   import dphy_tim_pkg::*;
#(
   parameter int RATE_W = 16,
   parameter int DIV_W  = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start_i,
   input  logic [RATE_W-1:0]             rate_i,
   input  logic [NUM_FIELDS-1:0]         ovr_mask_i,
   input  logic [NUM_FIELDS*FIELD_W-1:0] ovr_data_i,
   output logic                          busy_o,
   output logic                          done_o,
   output logic                          err_o,
   output logic                          ovf_o,
   output logic [31:0]                   word0_o,
   output logic [31:0]                   word1_o,
   output logic [31:0]                   word2_o,
   output logic [31:0]                   word3_o
);
   localparam int WORD_W = 4 * FIELD_W;

   if (DIV_W < 20 || RATE_W > DIV_W || RATE_W < 1) begin : g_bad_cfg
      $error("dphy_tim_gen: DIV_W must be >= 20 and >= RATE_W");
   end
   if (WORD_W != 32) begin : g_bad_word
      $error("dphy_tim_gen: packed words must be 32 bits");
   end

   logic                              busy;
   logic                              fin;
   logic [NUM_QUOT-1:0][DIV_W-1:0]    quots;
   logic [NUM_FIELDS-1:0]             mask_r;
   logic [NUM_FIELDS*FIELD_W-1:0]     data_r;
   logic [3:0][WORD_W-1:0]            packed_w;
   logic [3:0][WORD_W-1:0]            words_r;
   logic                              sat_any;
   logic                              done_r, err_r, ovf_r;
   logic                              accept;

   assign accept = start_i && !busy;

   dphy_tim_seq #(.W(DIV_W), .RATE_W(RATE_W)) seq_i (
      .clk  (clk),
      .rst_n(rst_n),
      .start(start_i),
      .rate (rate_i),
      .busy (busy),
      .fin  (fin),
      .quots(quots)
   );

   dphy_tim_pack #(.W(DIV_W)) pack_i (
      .quots   (quots),
      .ovr_mask(mask_r),
      .ovr_data(data_r),
      .words   (packed_w),
      .sat_any (sat_any)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_r  <= '0;
         data_r  <= '0;
         words_r <= '0;
         done_r  <= 1'b0;
         err_r   <= 1'b0;
         ovf_r   <= 1'b0;
      end else begin
         done_r <= 1'b0;
         if (accept) begin
            mask_r <= ovr_mask_i;
            data_r <= ovr_data_i;
            if (rate_i == '0) begin
               done_r <= 1'b1;
               err_r  <= 1'b1;
            end
         end
         if (fin) begin
            words_r <= packed_w;
            done_r  <= 1'b1;
            err_r   <= 1'b0;
            ovf_r   <= ovf_r | sat_any;
         end
      end
   end

   assign busy_o  = busy;
   assign done_o  = done_r;
   assign err_o   = err_r;
   assign ovf_o   = ovf_r;
   assign word0_o = words_r[0];
   assign word1_o = words_r[1];
   assign word2_o = words_r[2];
   assign word3_o = words_r[3];

   // R8
   zero_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && rate_i == '0) |=> (done_o && err_o && !busy_o));

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!done_o || $past(start_i)));

   // R6
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |=> ovf_o);

   // R11
   words_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(word0_o) && $stable(word1_o) &&
                   $stable(word2_o) && $stable(word3_o)));

   // R5
   zero_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (word2_o[7:0] == 8'h00 && word3_o[31:24] == 8'h00));

endmodule

// File: tb/dphy_tim_gen_tb_top.sv
`timescale 1ns/1ps
module dphy_tim_gen_tb_top;
   localparam int RATE_W = 16;
   localparam int DIV_W  = 32;
   localparam int LAT    = 10 * (DIV_W + 2) + 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic [RATE_W-1:0] rate_i = '0;
   logic [13:0]       ovr_mask_i = '0;
   logic [111:0]      ovr_data_i = '0;
   logic              busy_o, done_o, err_o, ovf_o;
   logic [31:0]       word0_o, word1_o, word2_o, word3_o;

   int n_chk = 0;
   int n_err = 0;
   int cyc = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   dphy_tim_gen #(.RATE_W(RATE_W), .DIV_W(DIV_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .rate_i(rate_i),
      .ovr_mask_i(ovr_mask_i), .ovr_data_i(ovr_data_i),
      .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .ovf_o(ovf_o),
      .word0_o(word0_o), .word1_o(word1_o), .word2_o(word2_o), .word3_o(word3_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
      end
   endtask

   function automatic int cdiv(input int n, input int d);
      return (n + d - 1) / d;
   endfunction

   // behavioural reference of the packed result
   function automatic void calc(input int r, input logic [13:0] mk, input logic [111:0] dt,
                                output logic [31:0] w0, output logic [31:0] w1,
                                output logic [31:0] w2, output logic [31:0] w3,
                                output bit sat);
      int ui, cy;
      int f[14];
      logic [7:0] b[14];
      ui = 1000 / r + 1;
      cy = 8000 / r + 1;
      f[0]  = cdiv(60, cy);
      f[1]  = cdiv(50 + 5 * ui, cy);
      f[2]  = cdiv(110 + 6 * ui, cy);
      f[3]  = cdiv(4 * ui + 77, cy);
      f[4]  = 4 * f[0];
      f[5]  = (3 * f[0]) / 2;
      f[6]  = 5 * f[0];
      f[7]  = 2 * f[0];
      f[8]  = 1;
      f[9]  = cdiv(336, cy);
      f[10] = cdiv(100, cy) + 10;
      f[11] = cdiv(64, cy);
      f[12] = cdiv(80 + 52 * ui, cy);
      f[13] = 2 * f[0];
      sat = 0;
      for (int i = 0; i < 14; i++) begin
         if (mk[i]) b[i] = dt[i*8 +: 8];
         else if (f[i] > 255) begin b[i] = 8'hff; sat = 1; end
         else b[i] = f[i][7:0];
      end
      w0 = {b[3], b[2], b[1], b[0]};
      w1 = {b[7], b[6], b[5], b[4]};
      w2 = {b[10], b[9], b[8], 8'h00};
      w3 = {8'h00, b[13], b[12], b[11]};
   endfunction

   // cycle-by-cycle reference state
   bit          m_busy, m_done, m_err, m_ovf;
   int          m_cnt;
   int          m_rate;
   logic [13:0] m_mask;
   logic [111:0] m_data;
   logic [31:0] m_w0, m_w1, m_w2, m_w3;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_err = 0; m_ovf = 0; m_cnt = 0;
         m_w0 = 0; m_w1 = 0; m_w2 = 0; m_w3 = 0;
      end else begin
         m_done = 0;
         if (m_busy) begin
            m_cnt--;
            if (m_cnt == 0) begin
               bit s;
               m_busy = 0; m_done = 1; m_err = 0;
               calc(m_rate, m_mask, m_data, m_w0, m_w1, m_w2, m_w3, s);
               m_ovf = m_ovf | s;
            end
         end else if (start_i) begin
            if (rate_i == 0) begin
               m_done = 1; m_err = 1;
            end else begin
               m_busy = 1; m_cnt = LAT; m_rate = int'(rate_i);
               m_mask = ovr_mask_i; m_data = ovr_data_i;
            end
         end
      end
   end

   always @(negedge clk) begin
      cyc++;
      if (rst_n && !finished) begin
         chk("R9 busy", {31'b0, busy_o}, {31'b0, m_busy});
         chk("R9 done", {31'b0, done_o}, {31'b0, m_done});
         chk("R8 err", {31'b0, err_o}, {31'b0, m_err});
         chk("R6 ovf", {31'b0, ovf_o}, {31'b0, m_ovf});
         chk("R11 word0", word0_o, m_w0);
         chk("R11 word1", word1_o, m_w1);
         chk("R11 word2", word2_o, m_w2);
         chk("R11 word3", word3_o, m_w3);
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   always @(negedge clk) begin
      if (cyc > 150000 && !finished) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=running expected=finished");
         finish_run();
      end
   end

   task automatic pulse(input int r, input logic [13:0] mk, input logic [111:0] dt);
      start_i = 1; rate_i = RATE_W'(r); ovr_mask_i = mk; ovr_data_i = dt;
      @(negedge clk);
      start_i = 0;
   endtask

   task automatic wait_done();
      int n = 0;
      while (!done_o && n < 2000) begin @(negedge clk); n++; end
   endtask

   task automatic run_named(input int r, input logic [13:0] mk, input logic [111:0] dt);
      logic [31:0] e0, e1, e2, e3;
      bit s;
      @(negedge clk);
      pulse(r, mk, dt);
      wait_done();
      calc(r, mk, dt, e0, e1, e2, e3, s);
      chk("R1 R2 word0", word0_o, e0);
      chk("R3 word1", word1_o, e1);
      chk("R4 word2", word2_o, e2);
      chk("R4 word3", word3_o, e3);
      chk("R5 zero bytes", {word2_o[7:0], word3_o[31:24]}, 32'h0);
   endtask

   initial begin
      logic [31:0] keep0;
      logic [111:0] od;
      repeat (3) @(negedge clk);
      // R12 reset state
      chk("R12 word0", word0_o, 0);
      chk("R12 word3", word3_o, 0);
      chk("R12 flags", {busy_o, done_o, err_o, ovf_o}, 0);
      rst_n = 1;
      run_named(1000, '0, '0);
      run_named(300, '0, '0);
      run_named(1, '0, '0);
      run_named(2500, '0, '0);
      run_named(4000, '0, '0);
      chk("R6 no ovf yet", {31'b0, ovf_o}, 0);

      // R7 override lpx and clk_post; derived fields keep computed lpx
      od = '0; od[0*8 +: 8] = 8'hab; od[12*8 +: 8] = 8'h05;
      run_named(1200, 14'h1001, od);
      chk("R7 lpx override", {24'b0, word0_o[7:0]}, 32'hab);
      chk("R7 ta_go computed", {24'b0, word1_o[7:0]}, 32'd4 * 32'(cdiv(60, 8000/1200 + 1)));

      // R7 R6 override the saturating fields: no overflow
      od = '0; od[6*8 +: 8] = 8'h11; od[9*8 +: 8] = 8'h22;
      run_named(65535, 14'h0240, od);
      chk("R6 R7 overridden no ovf", {31'b0, ovf_o}, 0);

      // R8 zero rate
      keep0 = word0_o;
      @(negedge clk);
      pulse(0, '0, '0);
      chk("R8 done", {31'b0, done_o}, 1);
      chk("R8 err", {31'b0, err_o}, 1);
      chk("R8 words kept", word0_o, keep0);
      run_named(800, '0, '0);
      chk("R8 err cleared", {31'b0, err_o}, 0);

      // R10 start while busy
      @(negedge clk);
      pulse(700, '0, '0);
      repeat (5) @(negedge clk);
      pulse(3000, '0, '0);
      wait_done();
      begin
         logic [31:0] e0, e1, e2, e3; bit s;
         calc(700, '0, '0, e0, e1, e2, e3, s);
         chk("R10 first request kept", word0_o, e0);
      end
      // back-to-back: start in the done cycle
      pulse(1500, '0, '0);
      chk("R9 accepted at done", {31'b0, busy_o}, 1);
      wait_done();

      // R6 saturation and sticky flag
      run_named(65535, '0, '0);
      chk("R6 ta_get clamp", {24'b0, word1_o[23:16]}, 32'hff);
      chk("R6 ovf set", {31'b0, ovf_o}, 1);
      run_named(1000, '0, '0);
      chk("R6 ovf sticky", {31'b0, ovf_o}, 1);

      // R12 reset again
      @(negedge clk); rst_n = 0;
      @(negedge clk);
      chk("R12 after reset", {busy_o, done_o, err_o, ovf_o}, 0);
      chk("R12 words", word1_o, 0);
      rst_n = 1;
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule